// File: doc/BRIEF.md
# Selectable Line-Code Serial Encoder

This block turns a serial bit stream into a line-coded transmit level. Two strobes pace it. `cell_start` marks the boundary of each bit cell, and `half_point` marks the middle of the cell. A 3-bit selector picks one of five line codes: plain NRZ, NRZI, FM0, Manchester or differential Manchester. An invert control turns the NRZI code into its space variant and FM0 into FM1. A reserved selector value parks the line high and raises an error flag.

The encoded level drives the transmit pin. When local loopback is on, the same level also feeds the receive path in place of the external receive pin. When no data is offered at a cell boundary, the line returns to the high idle level and the encoder restarts from that level. Shift registers, framing, CRC and modem handshakes belong to the blocks around it.

Top module: `lc_line_coder`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `tx_line` is 1, `rx_out` is 1 and `code_err` is 0.
- R2: Selector 000 (NRZ, the reset default) drives `tx_line` to the data bit for the whole cell.
- R3: Selector 001 (NRZI) toggles the line at the cell start when the bit is 1 and holds it when the bit is 0. With `invert` high, the toggle happens on a 0 instead. Nothing changes at mid-cell.
- R4: Selector 010 (FM0) toggles the line at every cell start, and toggles it again at mid-cell when the bit is 0. With `invert` high (FM1), the mid-cell toggle happens when the bit is 1.
- R5: Selector 100 (Manchester) drives the inverse of the bit in the first half-cell and the bit itself in the second half, so a 1 goes low then high.
- R6: Selector 110 (differential Manchester) toggles the line at every mid-cell, and toggles it at the cell start only when the bit is 0.
- R7: `invert` has no effect on selectors 000, 100 and 110.
- R8: Selectors 011, 101 and 111 are reserved. While one is selected, `tx_line` is 1 and `code_err` is 1 from the next clock on. `code_err` is 0 one clock after any other selector.
- R9: A `cell_start` with `tx_valid` low drives `tx_line` to 1, and a `half_point` inside such an idle cell leaves the line unchanged.
- R10: When `cell_start` and `half_point` are high in the same cycle, only the cell-start action is taken.
- R11: `tx_line` changes only on the clock edge that samples a strobe or a reserved selector. On every other edge it holds its value.
- R12: When `loopback` is high, `rx_out` equals `tx_line` in the cycle after. When `loopback` is low, `rx_out` is `rx_pin` delayed by one clock, whatever the transmitter does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cell_start | input | 1 | Strobe at a bit-cell boundary |
| half_point | input | 1 | Strobe at the middle of a bit cell |
| tx_valid | input | 1 | A data bit is offered with this cell_start |
| bit_in | input | 1 | Data bit, sampled with cell_start |
| code_sel | input | 3 | Line-code selector |
| invert | input | 1 | Selects the NRZI-space and FM1 variants |
| loopback | input | 1 | Routes the encoded line to the receive output |
| rx_pin | input | 1 | External receive pin |
| tx_line | output | 1 | Encoded transmit level (registered) |
| rx_out | output | 1 | Receive data toward the receiver (registered) |
| code_err | output | 1 | A reserved selector is in use (registered) |

## Verification
Every selector value is swept with both invert settings. Each sweep runs all sixteen 4-bit patterns, and the line is checked after each half-cell. The patterns include runs of equal bits and alternating bits, so both the toggle and the hold branch of each code are reached from both line levels. That is what separates NRZI from NRZ and FM0 from FM1. Every frame starts from an idle cell, so a wrong restart level shows up at once. Targeted steps then cover a mid-cell strobe inside an idle cell, coincident strobes, and loopback with the external pin held opposite to the line.

// File: rtl/lc_pkg.sv
package lc_pkg;
  localparam int SEL_W = 3;

  typedef enum logic [2:0] {
    LM_NRZ,
    LM_NRZI,
    LM_FM,
    LM_MAN,
    LM_DMAN,
    LM_RSV
  } lc_mode_e;
endpackage

// File: rtl/lc_code_decode.sv
module lc_code_decode
  import lc_pkg::*;
(
  input  logic [SEL_W-1:0] sel,
  output lc_mode_e         mode,
  output logic             rsv
);
  always_comb begin
    case (sel)
      3'b000:  mode = LM_NRZ;
      3'b001:  mode = LM_NRZI;
      3'b010:  mode = LM_FM;
      3'b100:  mode = LM_MAN;
      3'b110:  mode = LM_DMAN;
      default: mode = LM_RSV;
    endcase
    rsv = (mode == LM_RSV);
  end
endmodule

// File: rtl/lc_level_step.sv
// Next line level for one half of a bit cell. MID picks the half.
module lc_level_step
  import lc_pkg::*;
#(
  parameter bit MID = 1'b0
) (
  input  lc_mode_e mode,
  input  logic     inv,
  input  logic     dbit,
  input  logic     lvl,
  output logic     nxt
);
  generate
    if (MID) begin : g_mid
      always_comb begin
        case (mode)
          LM_NRZ:  nxt = lvl;
          LM_NRZI: nxt = lvl;
          LM_FM:   nxt = (~dbit ^ inv) ? ~lvl : lvl;
          LM_MAN:  nxt = dbit;
          LM_DMAN: nxt = ~lvl;
          default: nxt = 1'b1;
        endcase
      end
    end else begin : g_head
      always_comb begin
        case (mode)
          LM_NRZ:  nxt = dbit;
          LM_NRZI: nxt = (dbit ^ inv) ? ~lvl : lvl;
          LM_FM:   nxt = ~lvl;
          LM_MAN:  nxt = ~dbit;
          LM_DMAN: nxt = dbit ? lvl : ~lvl;
          default: nxt = 1'b1;
        endcase
      end
    end
  endgenerate
endmodule

// File: rtl/lc_loop_sel.sv
module lc_loop_sel #(
  parameter logic IDLE_LVL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic loopback,
  input  logic line_nxt,
  input  logic rx_pin,
  output logic rx_q
);
  always_ff @(posedge clk) begin
    if (rst) rx_q <= IDLE_LVL;
    else     rx_q <= loopback ? line_nxt : rx_pin;
  end
endmodule

// File: rtl/lc_line_coder.sv
module lc_line_coder
  import lc_pkg::*;
#(
  parameter logic IDLE_LVL = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cell_start,
  input  logic             half_point,
  input  logic             tx_valid,
  input  logic             bit_in,
  input  logic [SEL_W-1:0] code_sel,
  input  logic             invert,
  input  logic             loopback,
  input  logic             rx_pin,
  output logic             tx_line,
  output logic             rx_out,
  output logic             code_err
);
  lc_mode_e mode;
  logic     rsv;
  logic     line_q, line_d;
  logic     bit_q, act_q, err_q;
  logic     head_lvl, mid_lvl;

  lc_code_decode u_dec (
    .sel  (code_sel),
    .mode (mode),
    .rsv  (rsv)
  );

  lc_level_step #(.MID(1'b0)) u_head (
    .mode (mode),
    .inv  (invert),
    .dbit (bit_in),
    .lvl  (line_q),
    .nxt  (head_lvl)
  );

  lc_level_step #(.MID(1'b1)) u_mid (
    .mode (mode),
    .inv  (invert),
    .dbit (bit_q),
    .lvl  (line_q),
    .nxt  (mid_lvl)
  );

  // Cell start outranks mid-cell; a reserved code outranks both.
  always_comb begin
    if (rsv)                      line_d = IDLE_LVL;
    else if (cell_start)          line_d = tx_valid ? head_lvl : IDLE_LVL;
    else if (half_point && act_q) line_d = mid_lvl;
    else                          line_d = line_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      line_q <= IDLE_LVL;
      bit_q  <= 1'b0;
      act_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      line_q <= line_d;
      err_q  <= rsv;
      if (cell_start) begin
        bit_q <= bit_in;
        act_q <= tx_valid & ~rsv;
      end else if (rsv) begin
        act_q <= 1'b0;
      end
    end
  end

  lc_loop_sel #(.IDLE_LVL(IDLE_LVL)) u_loop (
    .clk      (clk),
    .rst      (rst),
    .loopback (loopback),
    .line_nxt (line_d),
    .rx_pin   (rx_pin),
    .rx_q     (rx_out)
  );

  assign tx_line  = line_q;
  assign code_err = err_q;
endmodule

// File: rtl/lc_line_coder_chk.sv
module lc_line_coder_chk (
  input logic       clk,
  input logic       rst,
  input logic       cell_start,
  input logic       half_point,
  input logic       tx_valid,
  input logic       bit_in,
  input logic [2:0] code_sel,
  input logic       loopback,
  input logic       rx_pin,
  input logic       tx_line,
  input logic       rx_out,
  input logic       code_err
);
  logic rsv_sel;
  assign rsv_sel = code_sel[0] & (code_sel[2:1] != 2'b00);

  assert_nrz_level_R2: assert property (@(posedge clk) disable iff (rst)
    (cell_start && tx_valid && code_sel == 3'b000) |=> (tx_line == $past(bit_in)));

  assert_fm_head_toggle_R4: assert property (@(posedge clk) disable iff (rst)
    (cell_start && tx_valid && code_sel == 3'b010) |=> (tx_line != $past(tx_line)));

  assert_man_head_R5: assert property (@(posedge clk) disable iff (rst)
    (cell_start && tx_valid && code_sel == 3'b100) |=> (tx_line == !$past(bit_in)));

  assert_reserved_idle_R8: assert property (@(posedge clk) disable iff (rst)
    rsv_sel |=> (tx_line && code_err));

  assert_err_clear_R8: assert property (@(posedge clk) disable iff (rst)
    !rsv_sel |=> !code_err);

  assert_idle_cell_R9: assert property (@(posedge clk) disable iff (rst)
    (cell_start && !tx_valid) |=> tx_line);

  assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (!cell_start && !half_point && !rsv_sel) |=> $stable(tx_line));

  assert_loop_on_R12: assert property (@(posedge clk) disable iff (rst)
    loopback |=> (rx_out == tx_line));

  assert_loop_off_R12: assert property (@(posedge clk) disable iff (rst)
    !loopback |=> (rx_out == $past(rx_pin)));
endmodule

bind lc_line_coder lc_line_coder_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .cell_start (cell_start),
  .half_point (half_point),
  .tx_valid   (tx_valid),
  .bit_in     (bit_in),
  .code_sel   (code_sel),
  .loopback   (loopback),
  .rx_pin     (rx_pin),
  .tx_line    (tx_line),
  .rx_out     (rx_out),
  .code_err   (code_err)
);

// File: tb/lc_line_coder_bench.sv
module lc_line_coder_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cell_start = 1'b0, half_point = 1'b0, tx_valid = 1'b0, bit_in = 1'b0;
  logic [2:0] code_sel = 3'b000;
  logic       invert = 1'b0, loopback = 1'b0, rx_pin = 1'b1;
  logic       tx_line, rx_out, code_err;

  int total = 0;
  int bad   = 0;
  logic exp_l;

  always #5 clk = ~clk;

  lc_line_coder u_lc_line_coder (
    .clk(clk), .rst(rst), .cell_start(cell_start), .half_point(half_point),
    .tx_valid(tx_valid), .bit_in(bit_in), .code_sel(code_sel), .invert(invert),
    .loopback(loopback), .rx_pin(rx_pin), .tx_line(tx_line), .rx_out(rx_out),
    .code_err(code_err)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  // Drive a strobe for one clock, then return at the next falling edge.
  task automatic strobe(input logic cs, input logic hp, input logic b, input logic v);
    @(negedge clk);
    cell_start = cs; half_point = hp; bit_in = b; tx_valid = v;
    @(negedge clk);
    cell_start = 0; half_point = 0;
  endtask

  function automatic logic model(input logic [2:0] c, input logic inv,
                                 input logic b, input logic l, input logic mid);
    logic tog;
    case (c)
      3'b000: return mid ? l : b;
      3'b001: begin tog = b ^ inv; return (!mid && tog) ? !l : l; end
      3'b010: begin tog = !b ^ inv; return mid ? (tog ? !l : l) : !l; end
      3'b100: return mid ? b : !b;
      3'b110: return mid ? !l : (b ? l : !l);
      default: return 1'b1;
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] c, input logic inv);
    case (c)
      3'b000: return inv ? "R7" : "R2";
      3'b001: return "R3";
      3'b010: return "R4";
      3'b100: return inv ? "R7" : "R5";
      3'b110: return inv ? "R7" : "R6";
      default: return "R8";
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R1", tx_line, 1'b1);
    chk("R1", rx_out, 1'b1);
    chk("R1", code_err, 1'b0);
    rst = 0;
    @(negedge clk);
    chk("R1", tx_line, 1'b1);
    chk("R1", code_err, 1'b0);

    // Sweep all selectors, both invert values, all 4-bit patterns.
    for (int c = 0; c < 8; c++) begin
      for (int iv = 0; iv < 2; iv++) begin
        @(negedge clk);
        code_sel = 3'(c); invert = iv[0];
        for (int p = 0; p < 16; p++) begin
          strobe(1, 0, 0, 0);
          exp_l = 1'b1;
          chk("R9", tx_line, exp_l);
          for (int k = 3; k >= 0; k--) begin
            strobe(1, 0, p[k], 1);
            exp_l = model(3'(c), iv[0], p[k], exp_l, 1'b0);
            chk(tag_of(3'(c), iv[0]), tx_line, exp_l);
            @(negedge clk);
            chk("R11", tx_line, exp_l);
            strobe(0, 1, 0, 0);
            exp_l = model(3'(c), iv[0], p[k], exp_l, 1'b1);
            chk(tag_of(3'(c), iv[0]), tx_line, exp_l);
            chk("R8", code_err, (c[0] && c[2:1] != 0));
          end
        end
      end
    end

    // Mid-cell strobe inside an idle cell leaves the line high.
    @(negedge clk); code_sel = 3'b100; invert = 0;
    strobe(1, 0, 0, 0);
    strobe(0, 1, 0, 0);
    chk("R9", tx_line, 1'b1);

    // Coincident strobes: only the head action (Manchester, bit 1 -> low).
    strobe(1, 1, 1, 1);
    chk("R10", tx_line, 1'b0);
    strobe(0, 1, 0, 0);
    chk("R10", tx_line, 1'b1);

    // Loopback off: rx_out follows rx_pin one clock later.
    @(negedge clk); code_sel = 3'b000; loopback = 0; rx_pin = 0;
    @(negedge clk);
    chk("R12", rx_out, 1'b0);
    rx_pin = 1;
    strobe(1, 0, 0, 1);
    chk("R12", rx_out, 1'b1);
    chk("R2", tx_line, 1'b0);

    // Loopback on: rx_out tracks tx_line and ignores rx_pin.
    @(negedge clk); loopback = 1; rx_pin = 1;
    @(negedge clk);
    chk("R12", rx_out, 1'b0);
    rx_pin = 0;
    strobe(1, 0, 1, 1);
    chk("R12", rx_out, 1'b1);
    chk("R2", tx_line, 1'b1);

    // Reserved code while a cell is running: line high, error set, then clears.
    @(negedge clk); loopback = 0;
    strobe(1, 0, 0, 1);
    chk("R2", tx_line, 1'b0);
    code_sel = 3'b101;
    @(negedge clk);
    chk("R8", tx_line, 1'b1);
    chk("R8", code_err, 1'b1);
    code_sel = 3'b000;
    @(negedge clk);
    chk("R8", code_err, 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule